// File: doc/BRIEF.md
# Adaptive dual-level amplitude slicer

The slicer receives one unsigned amplitude sample per carrier cycle of an amplitude-keyed carrier. For each sample it decides whether that cycle was a high-level or a low-level cycle. It then adapts its own decision threshold from what it has already seen. Two separate exponential averages are kept. One follows only the cycles judged high and the other follows only the cycles judged low. The threshold is placed between the two. Because neither average is diluted by the other class, a message in which most cycles are low does not pull the threshold down.

A second mode tracks only the high-level average and slices at two thirds of it. In that mode the low average is frozen. The block reports its current threshold, both level estimates and a locked flag for observation. The locked flag rises once each tracked average has absorbed enough updates to have moved away from its reset seed.

Top module: `amp_slicer`

## Requirements
- R1: A valid sample strictly greater than the current threshold is judged high (`level_o`=1). A sample less than or equal to the threshold is judged low (`level_o`=0).
- R2: With `mode_i`=0 (dual-level), `thresh_o` equals floor((hi_avg + lo_avg) / 2).
- R3: With `mode_i`=1 (high-only), `thresh_o` equals floor(2 * hi_avg / 3), and `lo_avg_o` is never updated.
- R4: On a high cycle the high average becomes avg + floor((x - avg) / 2^K), with K=4 by default. On a low cycle in dual-level mode the low average is updated the same way. Each average changes only on cycles of its own class.
- R5: While `rst_ni` is low, `hi_avg_o` is full scale (4095 at the default 12-bit width), `lo_avg_o` is 0, and `level_o`, `level_valid_o` and `locked_o` are 0.
- R6: `level_o` and `level_valid_o` are registered. Both appear one clock after the sample with `amp_valid_i`=1. `level_valid_o` is high for exactly one cycle per valid sample, and `level_o` holds its value between samples.
- R7: Clock cycles without `amp_valid_i` leave both averages and the outputs unchanged, apart from `level_valid_o`, which is 0.
- R8: `locked_o` is 1 once the high average has had 64 updates and, in dual-level mode, the low average has also had 64 updates. Before that point it is 0.
- R9: A long run of low cycles in dual-level mode leaves the high average unchanged. A high cycle after such a run is still judged high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = dual-level threshold, 1 = two thirds of high average |
| amp_valid_i | input | 1 | Amplitude sample valid |
| amp_i | input | DW (12) | Unsigned amplitude of one carrier cycle |
| level_valid_o | output | 1 | Decision strobe, one cycle after each sample |
| level_o | output | 1 | 1 = high cycle, 0 = low cycle |
| thresh_o | output | DW (12) | Current decision threshold |
| hi_avg_o | output | DW (12) | High-level average |
| lo_avg_o | output | DW (12) | Low-level average |
| locked_o | output | 1 | Averages have settled |

## Verification
`thresh_o` is combinational on the registered averages and `mode_i`. The bench therefore compares it in the same cycle a sample is presented, before the clock edge. The decision, its strobe and both updated averages are all due one edge later. The bench checks them one time unit after that rising edge, against a reference model it updates in step with each sample. `locked_o` is checked after the edge that delivers the 64th update of the last class. The idle check covers several edges without a sample and confirms that nothing but the strobe changes.

// File: rtl/amp_slicer_pkg.sv
package amp_slicer_pkg;
  typedef enum logic {
    MODE_DUAL       = 1'b0,
    MODE_TWO_THIRDS = 1'b1
  } slice_mode_e;

  localparam int unsigned TRK_HI = 0;
  localparam int unsigned TRK_LO = 1;
endpackage

// File: rtl/ema_track.sv
module ema_track #(
  parameter int unsigned DW       = 12,
  parameter int unsigned K        = 4,
  parameter bit          SEED_MAX = 1'b0,
  parameter int unsigned LOCK_CNT = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [DW-1:0] x_i,
  output logic [DW-1:0] avg_o,
  output logic          done_o
);
  localparam int unsigned CW = $clog2(LOCK_CNT + 1);
  localparam logic [DW-1:0] SEED = SEED_MAX ? {DW{1'b1}} : {DW{1'b0}};

  logic [DW-1:0]        avg_q;
  logic [CW-1:0]        cnt_q;
  logic signed [DW:0]   diff;
  logic signed [DW:0]   step;

  assign diff = $signed({1'b0, x_i}) - $signed({1'b0, avg_q});
  assign step = diff >>> K;   // floor division by 2^K

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_q <= SEED;
      cnt_q <= '0;
    end else if (upd_i) begin
      avg_q <= DW'($signed({1'b0, avg_q}) + step);
      if (cnt_q != CW'(LOCK_CNT)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign avg_o  = avg_q;
  assign done_o = (cnt_q == CW'(LOCK_CNT));
endmodule

// File: rtl/slice_thresh.sv
module slice_thresh #(
  parameter int unsigned DW = 12
) (
  input  amp_slicer_pkg::slice_mode_e mode_i,
  input  logic [DW-1:0]               hi_i,
  input  logic [DW-1:0]               lo_i,
  output logic [DW-1:0]               thresh_o
);
  import amp_slicer_pkg::*;

  logic [DW-1:0] mid;
  logic [DW-1:0] q3;
  logic [DW-1:0] r3;
  logic [DW-1:0] two_thirds;

  // floor((h+l)/2) without a carry bit
  assign mid = (hi_i >> 1) + (lo_i >> 1) + {{(DW-1){1'b0}}, hi_i[0] & lo_i[0]};

  // floor(2h/3) = 2*(h/3) + (h%3 == 2)
  assign q3 = hi_i / DW'(3);
  assign r3 = hi_i % DW'(3);
  assign two_thirds = (q3 << 1) + {{(DW-1){1'b0}}, r3 == DW'(2)};

  always_comb begin
    unique case (mode_i)
      MODE_TWO_THIRDS: thresh_o = two_thirds;
      default:         thresh_o = mid;
    endcase
  end
endmodule

// File: rtl/amp_slicer.sv
module amp_slicer #(
  parameter int unsigned DW       = 12,
  parameter int unsigned K        = 4,
  parameter int unsigned LOCK_CNT = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          amp_valid_i,
  input  logic [DW-1:0] amp_i,
  output logic          level_valid_o,
  output logic          level_o,
  output logic [DW-1:0] thresh_o,
  output logic [DW-1:0] hi_avg_o,
  output logic [DW-1:0] lo_avg_o,
  output logic          locked_o
);
  import amp_slicer_pkg::*;

  slice_mode_e   mode;
  logic          is_hi;
  logic [1:0]    upd;
  logic [1:0]    done;
  logic [DW-1:0] avg [2];

  assign mode  = slice_mode_e'(mode_i);
  assign is_hi = amp_i > thresh_o;   // equal counts as low

  assign upd[TRK_HI] = amp_valid_i & is_hi;
  assign upd[TRK_LO] = amp_valid_i & ~is_hi & (mode == MODE_DUAL);

  for (genvar g = 0; g < 2; g++) begin : g_trk
    ema_track #(
      .DW       (DW),
      .K        (K),
      .SEED_MAX (g == TRK_HI),
      .LOCK_CNT (LOCK_CNT)
    ) u_trk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (upd[g]),
      .x_i    (amp_i),
      .avg_o  (avg[g]),
      .done_o (done[g])
    );
  end

  slice_thresh #(.DW(DW)) u_thr (
    .mode_i   (mode),
    .hi_i     (avg[TRK_HI]),
    .lo_i     (avg[TRK_LO]),
    .thresh_o (thresh_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_valid_o <= 1'b0;
      level_o       <= 1'b0;
    end else begin
      level_valid_o <= amp_valid_i;
      if (amp_valid_i) level_o <= is_hi;
    end
  end

  assign hi_avg_o = avg[TRK_HI];
  assign lo_avg_o = avg[TRK_LO];
  assign locked_o = done[TRK_HI] & (mode_i | done[TRK_LO]);
endmodule

// File: rtl/amp_slicer_chk.sv
module amp_slicer_chk #(
  parameter int unsigned DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_i,
  input logic          amp_valid_i,
  input logic [DW-1:0] amp_i,
  input logic          level_valid_o,
  input logic          level_o,
  input logic [DW-1:0] thresh_o,
  input logic [DW-1:0] hi_avg_o,
  input logic [DW-1:0] lo_avg_o
);
  // R6
  strobe_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_valid_i |=> level_valid_o);
  // R6
  strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !amp_valid_i |=> !level_valid_o);
  // R1
  decision_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_valid_i |=> (level_o == $past(amp_i > thresh_o)));
  // R4
  hi_only_on_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_valid_i && amp_i <= thresh_o) |=> $stable(hi_avg_o));
  // R4
  lo_only_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_valid_i && amp_i > thresh_o) |=> $stable(lo_avg_o));
  // R3
  lo_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> $stable(lo_avg_o));
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !amp_valid_i |=> ($stable(hi_avg_o) && $stable(lo_avg_o) && $stable(level_o)));
endmodule

bind amp_slicer amp_slicer_chk #(.DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_i),
  .amp_valid_i   (amp_valid_i),
  .amp_i         (amp_i),
  .level_valid_o (level_valid_o),
  .level_o       (level_o),
  .thresh_o      (thresh_o),
  .hi_avg_o      (hi_avg_o),
  .lo_avg_o      (lo_avg_o)
);

// File: tb/amp_slicer_bench.sv
module amp_slicer_bench;
  localparam int unsigned DW = 12;
  localparam int unsigned VEC_N = 10;
  // {expected level, amplitude} from reset, dual-level mode
  localparam logic [DW:0] VEC [VEC_N] = '{
    {1'b1, 12'd3000}, {1'b0, 12'd200}, {1'b1, 12'd3100}, {1'b0, 12'd150},
    {1'b0, 12'd250},  {1'b1, 12'd2900}, {1'b0, 12'd100}, {1'b0, 12'd300},
    {1'b0, 12'd50},   {1'b1, 12'd3200}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic          valid = 1'b0;
  logic [DW-1:0] amp = '0;
  logic          level_valid, level, locked;
  logic [DW-1:0] thresh, hi_avg, lo_avg;

  int errors = 0;
  int checks = 0;
  int hi_m, lo_m;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  amp_slicer u_amp_slicer (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .amp_valid_i(valid), .amp_i(amp),
    .level_valid_o(level_valid), .level_o(level), .thresh_o(thresh),
    .hi_avg_o(hi_avg), .lo_avg_o(lo_avg), .locked_o(locked)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int model_thresh(input logic m);
    return m ? (hi_m * 2) / 3 : (hi_m + lo_m) / 2;
  endfunction

  // present one sample; check threshold before edge, results after it
  task automatic send(input logic m, input int a, input int exp_lvl, input bit full);
    int th;
    bit hi;
    @(negedge clk);
    mode = m; valid = 1'b1; amp = DW'(a);
    #0.5;
    th = model_thresh(m);
    hi = (a > th);
    if (full) chk(m ? "R3 thresh" : "R2 thresh", int'(thresh), th);
    if (hi) hi_m = hi_m + ((a - hi_m) >>> 4);
    else if (!m) lo_m = lo_m + ((a - lo_m) >>> 4);
    @(posedge clk); #0.5;
    if (full) begin
      chk("R1 level", int'(level), exp_lvl >= 0 ? exp_lvl : int'(hi));
      chk("R6 strobe", int'(level_valid), 1);
      chk("R4 hi_avg", int'(hi_avg), hi_m);
      chk("R4 lo_avg", int'(lo_avg), lo_m);
    end
  endtask

  task automatic do_reset;
    valid = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #0.5;
    hi_m = 4095; lo_m = 0;
    chk("R5 hi_avg", int'(hi_avg), 4095);
    chk("R5 lo_avg", int'(lo_avg), 0);
    chk("R5 level", int'(level), 0);
    chk("R5 strobe", int'(level_valid), 0);
    chk("R5 locked", int'(locked), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R2 reset thresh", int'(thresh), 2047);

    // table walk, dual-level
    for (int i = 0; i < VEC_N; i++)
      send(1'b0, int'(VEC[i][DW-1:0]), int'(VEC[i][DW]), 1'b1);

    // R7 idle: nothing moves, strobe drops
    begin
      int h0, l0, lv0;
      @(negedge clk); valid = 1'b0;
      h0 = int'(hi_avg); l0 = int'(lo_avg); lv0 = int'(level);
      repeat (5) @(posedge clk);
      #0.5;
      chk("R7 hi hold", int'(hi_avg), h0);
      chk("R7 lo hold", int'(lo_avg), l0);
      chk("R6 level hold", int'(level), lv0);
      chk("R6 strobe low", int'(level_valid), 0);
    end

    // R1 equal-to-threshold is low
    do_reset();
    send(1'b0, 2047, 0, 1'b1);
    chk("R1 equal lo", int'(lo_avg), 127);
    chk("R2 new thresh", int'(thresh), 2111);

    // R3 two-thirds mode
    do_reset();
    @(negedge clk); mode = 1'b1; #0.5;
    chk("R3 reset thresh", int'(thresh), 2730);
    send(1'b1, 2730, 0, 1'b1);
    send(1'b1, 3000, 1, 1'b1);
    chk("R3 hi step", int'(hi_avg), 4026);
    send(1'b1, 100, 0, 1'b1);
    chk("R3 lo frozen", int'(lo_avg), 0);

    // R8 lock counting
    do_reset();
    for (int i = 0; i < 63; i++) begin
      send(1'b0, 3000, -1, 1'b0);
      send(1'b0, 200, -1, 1'b0);
    end
    chk("R8 not locked 63", int'(locked), 0);
    send(1'b0, 200, -1, 1'b0);
    chk("R8 not locked hi 63", int'(locked), 0);
    send(1'b0, 3000, -1, 1'b0);
    chk("R8 locked", int'(locked), 1);
    chk("R4 hi track", int'(hi_avg), hi_m);
    chk("R4 lo track", int'(lo_avg), lo_m);

    // R9 long low run
    begin
      int h0;
      h0 = int'(hi_avg);
      for (int i = 0; i < 300; i++) send(1'b0, 150, 0, 1'b0);
      chk("R9 hi unmoved", int'(hi_avg), h0);
      chk("R9 lo tracks", int'(lo_avg), lo_m);
      send(1'b0, 2600, 1, 1'b1);
    end

    @(negedge clk); valid = 1'b0;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule